// File: doc/BRIEF.md
# Stereo Idle-Channel Auto-Mute Detector

This block looks at one left/right sample pair per audio frame and decides whether the incoming stream has gone idle. A channel word is idle when all of its bits are zero or all of its bits are one. The block counts the frames in which both channels are idle. When that run reaches a set length, 8192 frames by default, it raises a mute flag for the analog back end. The first frame in which either channel carries any other pattern drops the flag at once and restarts the run from zero.

The function is switched on by an active-low enable. With the enable high, the mute flag is held low and the run counter is cleared, so re-enabling always starts a fresh count. A frame strobe marks the cycle in which the sample pair is valid. Cycles without the strobe do not change the run or the flag. Output ramping and analog muting are handled elsewhere.

Top module: `auto_mute_detect`

## Requirements
- R1: While rst_ni is low and after its release, mute_o is 0 and the idle run is zero.
- R2: Each channel word is judged on its own: it is idle only when it equals all zeros or all ones (SAMPLE_W bits). One channel all zeros and the other all ones is an idle frame. Any word with both 0 and 1 bits is not idle.
- R3: A strobed frame with both channels idle extends the run by one. mute_o goes to 1 from the clock edge that samples the IDLE_FRAMES-th consecutive idle frame, and not before.
- R4: A strobed frame with either channel not idle clears the run, and mute_o is 0 from the clock edge that samples it.
- R5: Cycles with frame_i low leave both the run and mute_o unchanged, whatever the sample inputs carry.
- R6: The run saturates at IDLE_FRAMES. Further idle frames keep mute_o at 1 and never wrap the count.
- R7: While mute_en_ni is 1, mute_o is 0 in the same cycle (combinational gating), the run is cleared at each clock edge, and strobed frames are not counted.
- R8: After mute_en_ni returns to 0, a full IDLE_FRAMES consecutive idle frames are needed again before mute_o rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Strobe: sample pair valid this cycle |
| left_i | input | SAMPLE_W | Left channel sample word |
| right_i | input | SAMPLE_W | Right channel sample word |
| mute_en_ni | input | 1 | Auto-mute enable, active low |
| mute_o | output | 1 | Mute request |

## Verification
The bench builds the detector with SAMPLE_W = 6 and IDLE_FRAMES = 12. This brings the terminal count, saturation and release within a few dozen frames. The narrow word keeps the all-ones pattern and the single-bit-off patterns next to it easy to state exactly. With these values, the runs that stop one frame short of the threshold, and the full recount after re-enable, can be repeated several times in one short run.

// File: rtl/auto_mute_pkg.sv
package auto_mute_pkg;
  parameter int unsigned NUM_CH = 2;
  parameter int unsigned CH_LEFT = 0;
  parameter int unsigned CH_RIGHT = 1;
endpackage

// File: rtl/idle_word_detect.sv
module idle_word_detect #(
  parameter int unsigned SAMPLE_W = 20
) (
  input  logic [SAMPLE_W-1:0] word_i,
  output logic                idle_o
);
  // static pattern: every bit equal
  assign idle_o = (&word_i) | ~(|word_i);
endmodule

// File: rtl/idle_run_counter.sv
module idle_run_counter #(
  parameter int unsigned IDLE_FRAMES = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic restart_i,
  input  logic step_i,
  output logic at_term_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_FRAMES + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(IDLE_FRAMES);

  logic [CNT_W-1:0] run_q;
  logic             sat;

  assign sat = (run_q == TERM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (clear_i || restart_i) run_q <= '0;
    else if (step_i && !sat)      run_q <= run_q + 1'b1;
  end

  assign at_term_o = sat;

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= TERM);

  // R4
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> run_q == '0);

  // R3
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && !restart_i && run_q != TERM) |=> run_q == $past(run_q) + 1'b1);
endmodule

// File: rtl/auto_mute_detect.sv
module auto_mute_detect
  import auto_mute_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 20,
  parameter int unsigned IDLE_FRAMES = 8192
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                mute_en_ni,
  output logic                mute_o
);
  logic [SAMPLE_W-1:0] ch_word [NUM_CH];
  logic [NUM_CH-1:0]   ch_idle;
  logic                frame_idle, at_term;

  assign ch_word[CH_LEFT]  = left_i;
  assign ch_word[CH_RIGHT] = right_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    idle_word_detect #(.SAMPLE_W(SAMPLE_W)) u_idle (
      .word_i (ch_word[g]),
      .idle_o (ch_idle[g])
    );
  end

  assign frame_idle = &ch_idle;

  idle_run_counter #(.IDLE_FRAMES(IDLE_FRAMES)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (mute_en_ni),
    .restart_i (frame_i & ~frame_idle),
    .step_i    (frame_i & frame_idle),
    .at_term_o (at_term)
  );

  assign mute_o = at_term & ~mute_en_ni;

  // R7
  disabled_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_en_ni |-> !mute_o);

  // R4
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !mute_en_ni && !(&ch_idle)) |=> !mute_o);

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && !mute_en_ni) |=> (mute_o == $past(mute_o)) || mute_en_ni);
endmodule

// File: tb/tb_auto_mute_detect.sv
module tb_auto_mute_detect;
  localparam int unsigned SW = 6;
  localparam int unsigned NF = 12;
  localparam logic [SW-1:0] ONES = '1;
  localparam logic [SW-1:0] ZERO = '0;

  logic clk = 0, rst_ni = 0, frame = 0, en_n = 0;
  logic [SW-1:0] left = '0, right = '0;
  logic mute;
  int vectors = 0, miscompares = 0, run = 0;
  bit done = 0;

  always #5 clk = ~clk;

  auto_mute_detect #(.SAMPLE_W(SW), .IDLE_FRAMES(NF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame),
    .left_i(left), .right_i(right), .mute_en_ni(en_n), .mute_o(mute));

  function automatic bit word_idle(input logic [SW-1:0] w);
    return (w == ZERO) || (w == ONES);
  endfunction

  task automatic check(input logic exp, input string req);
    vectors++;
    if (mute !== exp) begin
      miscompares++;
      $display("FAIL %s: mute_o=%0b expected %0b at %0t", req, mute, exp, $time);
    end
  endtask

  task automatic apply(input logic fr, input logic [SW-1:0] l, input logic [SW-1:0] r,
                       input logic dis, input string req);
    @(negedge clk);
    frame = fr; left = l; right = r; en_n = dis;
    #1;
    check((run == NF) && !dis, req);
    @(posedge clk);
    if (dis) run = 0;
    else if (fr) begin
      if (word_idle(l) && word_idle(r)) run = (run < NF) ? run + 1 : NF;
      else run = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1 check(1'b0, "R1");
    rst_ni = 1;
    apply(0, 6'h15, 6'h2a, 0, "R1");

    // R3: zeros, one short then reach threshold
    for (int i = 0; i < NF - 1; i++) apply(1, ZERO, ZERO, 0, "R3");
    apply(0, ZERO, ZERO, 0, "R3");
    apply(1, ZERO, ZERO, 0, "R3");
    // R6: saturation
    for (int i = 0; i < 2 * NF; i++) apply(1, ZERO, ZERO, 0, "R6");
    // R5: no strobe with active data keeps mute
    for (int i = 0; i < 5; i++) apply(0, 6'h13, 6'h05, 0, "R5");
    apply(0, ZERO, ZERO, 0, "R5");
    // R4: right channel goes active
    apply(1, ZERO, 6'h01, 0, "R4");
    apply(0, ZERO, ZERO, 0, "R4");

    // R2: mixed all-ones / all-zeros counts as idle
    for (int i = 0; i < NF; i++) apply(1, ONES, ZERO, 0, "R2");
    apply(1, ZERO, ONES, 0, "R2");
    // R4: left one bit off all-ones
    apply(1, 6'h3e, ONES, 0, "R4");
    apply(0, ONES, ONES, 0, "R4");

    // R2: near-idle words break the run just short of threshold
    for (int i = 0; i < NF - 1; i++) apply(1, ONES, ONES, 0, "R2");
    apply(1, 6'h20, ZERO, 0, "R2");
    for (int i = 0; i < NF - 1; i++) apply(1, ZERO, ZERO, 0, "R2");
    apply(1, ZERO, 6'h1f, 0, "R2");
    apply(0, ZERO, ZERO, 0, "R2");

    // R5: gaps between idle frames
    for (int i = 0; i < NF; i++) begin
      apply(1, ZERO, ZERO, 0, "R5");
      apply(0, 6'h0c, 6'h33, 0, "R5");
    end
    apply(0, ZERO, ZERO, 0, "R5");

    // R7: disable while muted, frames ignored
    apply(1, ZERO, ZERO, 1, "R7");
    for (int i = 0; i < NF + 2; i++) apply(1, ZERO, ZERO, 1, "R7");
    // R8: re-enable needs full recount
    for (int i = 0; i < NF - 1; i++) apply(1, ONES, ONES, 0, "R8");
    apply(1, ONES, ONES, 0, "R8");
    apply(0, ONES, ONES, 0, "R8");
    // R7: disable pulse mid-run
    for (int i = 0; i < 4; i++) apply(1, ZERO, ZERO, 0, "R7");
    apply(0, ZERO, ZERO, 1, "R7");
    for (int i = 0; i < NF - 1; i++) apply(1, ZERO, ZERO, 0, "R8");
    apply(1, ZERO, ZERO, 0, "R8");
    apply(0, ZERO, ZERO, 0, "R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule